// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands and a 5-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equal, unsigned less-than or unsigned greater-than. The trap fires when at least one enabled relation holds.

A width select picks the comparison mode. Word mode compares only the low 32 bits, and its signed relations treat bit 31 as the sign. Doubleword mode compares all 64 bits, and bit 63 is the sign.

The result is a one-cycle registered request to the exception logic. The request carries a program-trap cause code. The pipeline presents one evaluation per cycle with a valid strobe. What happens after the request, such as exception entry, belongs to other logic.

Top module: `trapcmp_unit`

## Requirements
- R1: While reset is high, and in the cycle after reset ends with no valid input, `trap_req` is 0 and `trap_cause` is 0.
- R2: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed two's-complement numbers.
- R3: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed numbers.
- R4: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R5: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers. Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R6: The trap fires when the OR of all enabled relations is true, whatever combination of mask bits is set.
- R7: With `mode_dword` = 0 (word mode), only bits 31:0 of each operand are compared and bit 31 is the sign. Bits 63:32 have no effect on the result.
- R8: With `mode_dword` = 1 (doubleword mode), all 64 bits are compared and bit 63 is the sign.
- R9: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R10: `trap_req` goes high in the cycle after the clock edge that samples a valid evaluation whose condition holds, and stays high for exactly one cycle. Without `in_valid`, no trap is raised.
- R11: When `trap_req` is 1, `trap_cause` is 4'h2 (program trap). When `trap_req` is 0, `trap_cause` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Evaluation strobe |
| mode_dword | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| cond_mask | input | 5 | Relation enables: bit4 slt, bit3 sgt, bit2 eq, bit1 ult, bit0 ugt |
| trap_req | output | 1 | Registered trap request, one cycle |
| trap_cause | output | 4 | Cause tag of the request |

## Verification
Every cycle, the assertions check the following:
- the reset state;
- that a zero mask never traps and a full mask always traps;
- that a missing strobe gives no request;
- that the cause tag agrees with the request;
- that equal operands with the equality bit set always trap;
- that each signed relation is exclusive within its lane.

Some behaviour only the bench scenarios can show. Individual relations and their OR, the masking of the upper word in 32-bit mode, and the difference in sign position between the two modes need computed expectations. The bench gets these from directed sign-boundary operands and from random operands biased toward equal values.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;

    localparam int DATA_W  = 64;
    localparam int WORD_W  = 32;
    localparam int MASK_W  = 5;
    localparam int CAUSE_W = 4;
    localparam int N_LANES = 2;

    localparam logic [CAUSE_W-1:0] CAUSE_IDLE = 4'h0;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

    // Field order matches the mask bit positions (bit 4 down to bit 0).
    typedef struct packed {
        logic s_lt;
        logic s_gt;
        logic eq;
        logic u_lt;
        logic u_gt;
    } relation_t;

    typedef enum logic {
        LANE_WORD  = 1'b0,
        LANE_DWORD = 1'b1
    } lane_sel_e;

    function automatic logic any_enabled(input relation_t rel, input logic [MASK_W-1:0] mask);
        return |(rel & mask);
    endfunction

endpackage

// File: rtl/trapcmp_relate.sv
module trapcmp_relate
    import trapcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output relation_t    rel
);
    logic u_lt, u_gt, same, sign_differs;

    always_comb begin
        same         = (a == b);
        u_lt         = (a < b);
        u_gt         = !same && !u_lt;
        sign_differs = a[W-1] ^ b[W-1];
        rel.eq   = same;
        rel.u_lt = u_lt;
        rel.u_gt = u_gt;
        // With differing signs, the negative operand is the smaller one.
        rel.s_lt = sign_differs ? a[W-1] : u_lt;
        rel.s_gt = sign_differs ? b[W-1] : u_gt;
    end

    always_comb begin
        assert ($onehot({rel.s_lt, rel.s_gt, rel.eq}))   // R2 R3 R4
            else $error("AST_SIGNED_EXCLUSIVE");
    end
endmodule

// File: rtl/trapcmp_select.sv
module trapcmp_select
    import trapcmp_pkg::*;
(
    input  relation_t            rel,
    input  logic [MASK_W-1:0]    mask,
    output logic                 hit
);
    logic [MASK_W-1:0] term;

    for (genvar i = 0; i < MASK_W; i++) begin : g_term
        assign term[i] = mask[i] & rel[i];
    end

    assign hit = |term;
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               mode_dword,
    input  logic [63:0]        opnd_a,
    input  logic [63:0]        opnd_b,
    input  logic [4:0]         cond_mask,
    output logic               trap_req,
    output logic [3:0]         trap_cause
);
    relation_t lane_rel [N_LANES];
    relation_t rel_sel;
    logic      hit;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == int'(LANE_WORD)) ? WORD_W : DATA_W;
        trapcmp_relate #(.W(LW)) u_rel (
            .a   (opnd_a[LW-1:0]),
            .b   (opnd_b[LW-1:0]),
            .rel (lane_rel[g])
        );
    end

    assign rel_sel = mode_dword ? lane_rel[int'(LANE_DWORD)] : lane_rel[int'(LANE_WORD)];

    trapcmp_select u_sel (
        .rel  (rel_sel),
        .mask (cond_mask),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req   <= 1'b0;
            trap_cause <= CAUSE_IDLE;
        end else begin
            trap_req   <= in_valid && hit;
            trap_cause <= (in_valid && hit) ? CAUSE_TRAP : CAUSE_IDLE;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!trap_req && trap_cause == CAUSE_IDLE)) else $error("AST_RESET_QUIET"); // R1
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst) (in_valid && cond_mask == '0) |=> !trap_req) else $error("AST_ZERO_MASK"); // R9
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst) (in_valid && &cond_mask) |=> trap_req) else $error("AST_FULL_MASK"); // R9
    AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !trap_req) else $error("AST_NEEDS_VALID"); // R10
    AST_EQ_TRAPS: assert property (@(posedge clk) disable iff (rst) (in_valid && cond_mask[2] && opnd_a == opnd_b) |=> trap_req) else $error("AST_EQ_TRAPS"); // R4
    AST_CAUSE_TAG: assert property (@(posedge clk) disable iff (rst) trap_cause == (trap_req ? CAUSE_TRAP : CAUSE_IDLE)) else $error("AST_CAUSE_TAG"); // R11
endmodule

// File: tb/tb_trapcmp_unit.sv
module tb_trapcmp_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        mode_dword;
    logic [63:0] opnd_a, opnd_b;
    logic [4:0]  cond_mask;
    logic        trap_req;
    logic [3:0]  trap_cause;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trapcmp_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_dword(mode_dword),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_mask(cond_mask),
        .trap_req(trap_req), .trap_cause(trap_cause)
    );

    // Reference model: relation by bit walk from the top.
    function automatic bit ref_trap(input logic [63:0] a, input logic [63:0] b,
                                    input logic [4:0] m, input bit dw);
        int top = dw ? 63 : 31;
        int cmp = 0;        // -1 a<b unsigned, 1 a>b, 0 equal
        bit slt, sgt, ult, ugt, eq;
        for (int i = top; i >= 0; i--) begin
            if (cmp == 0 && a[i] != b[i]) cmp = a[i] ? 1 : -1;
        end
        eq  = (cmp == 0);
        ult = (cmp < 0);
        ugt = (cmp > 0);
        if (a[top] == b[top]) begin
            slt = ult; sgt = ugt;
        end else begin
            slt = a[top]; sgt = b[top];
        end
        return (m[4] && slt) || (m[3] && sgt) || (m[2] && eq) || (m[1] && ult) || (m[0] && ugt);
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_vec++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m,
                         input bit dw, input string req);
        bit e = ref_trap(a, b, m, dw);
        @(negedge clk);
        opnd_a = a; opnd_b = b; cond_mask = m; mode_dword = dw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a = '0; opnd_b = '1;
        check(trap_req == e, req, trap_req, e);
        check(trap_cause == (e ? 4'h2 : 4'h0), "R11", trap_cause, e ? 2 : 0);
        @(negedge clk);
        check(trap_req == 1'b0, "R10", trap_req, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] a, b;
        void'($urandom(32'd2718));
        rst = 1'b1; in_valid = 1'b0; mode_dword = 1'b0;
        opnd_a = '0; opnd_b = '0; cond_mask = '0;
        repeat (3) @(negedge clk);
        check(trap_req == 0 && trap_cause == 0, "R1", trap_req, 0);
        rst = 1'b0;
        @(negedge clk);
        check(trap_req == 0 && trap_cause == 0, "R1", trap_cause, 0);

        // R2 R3: sign boundaries in each mode
        apply(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b0, "R2");
        apply(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b1, "R8");
        apply(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08, 1'b1, "R3");
        apply(64'h8000_0000_0000_0000, 64'h0, 5'h08, 1'b1, "R8");
        // R4 equality
        apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b1, "R4");
        // R5 unsigned
        apply(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, "R5");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01, 1'b1, "R5");
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h02, 1'b1, "R5");
        // R7 upper bits ignored in word mode
        apply(64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0, "R7");
        apply(64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005, 5'h1B, 1'b0, "R7");
        apply(64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005, 5'h01, 1'b1, "R8");
        // R6 combinations, R9 extremes
        apply(64'h5, 64'h7, 5'h0A, 1'b1, "R6");
        apply(64'h5, 64'h7, 5'h12, 1'b1, "R6");
        apply(64'h5, 64'h5, 5'h00, 1'b1, "R9");
        apply(64'h5, 64'h9, 5'h1F, 1'b0, "R9");
        // R10: valid absent with trapping inputs
        @(negedge clk);
        opnd_a = 64'h3; opnd_b = 64'h3; cond_mask = 5'h1F; in_valid = 1'b0;
        @(negedge clk);
        check(trap_req == 1'b0, "R10", trap_req, 0);

        for (int i = 0; i < 3000; i++) begin
            a = {$urandom, $urandom};
            case ($urandom % 4)
                0: b = a;
                1: b = {$urandom, a[31:0]};
                default: b = {$urandom, $urandom};
            endcase
            apply(a, b, 5'($urandom), 1'($urandom), "R6");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule